// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-facing control and status register set of a simple bus-master DMA channel. A word-wide register window holds four 32-bit registers: a control/status word, a transfer address, a transfer count and an upper-address extension. The bus that carries the data, the FIFO and the address translation live elsewhere. This block only stores what software programs and turns it into the level and pulse signals that the rest of the channel and the attached peripheral consume.

The control word holds an interrupt-enable bit, a transfer-direction bit, a channel-enable bit, two self-clearing command bits (peripheral reset and FIFO drain) and a group of bits that software can read but cannot write. Those read-only bits are a fixed version code, an "address loaded" flag and the pending-interrupt bit. The pending-interrupt bit follows an incoming interrupt request. The block drives a registered interrupt output only while interrupt enable is set. By default the window is eight words wide. Offsets up to 0x1F fold onto the four registers, and anything above reads zero. A parameter selects a narrow variant that folds every offset.

Top module: `dmachan_regfile`

## Requirements
- R1: After reset the control word reads 0xA0000000. The address, count and upper-address registers read zero. irq_out, chan_en and periph_rst are low.
- R2: The register index is byte-address bits [3:2]: 0 control, 1 address, 2 count, 3 upper address. In-window offsets 0x10 to 0x1F reach the same registers as 0x00 to 0x0F.
- R3: The address, count and upper-address registers read back the last full-word value written to them. A write to the address register sets control bit 26 ("address loaded"), which is visible on the next cycle.
- R4: Control bits under mask 0xFE000007 (bits 31:25 and 2:0) are read-only. A control write keeps their old values and takes every other bit, except the command bits, from the write data.
- R5: A control write with bit 7 set drives periph_rst high for exactly the one cycle after the write. Bit 7 always reads back as zero.
- R6: A control write with bit 6 (drain) set and bit 7 clear stores bit 6 as zero. When bits 6 and 7 are both set, bit 6 is stored as one.
- R7: chan_en follows control bit 9. It rises or falls in the cycle after the control write that sets or clears that bit.
- R8: Control bit 0 (pending interrupt) equals the level of irq_in sampled at the previous clock edge.
- R9: irq_out is high exactly when both the pending bit and interrupt enable (control bit 4) are set. It follows a write of bit 4 or a change of irq_in one cycle later.
- R10: A write whose byte strobes are not all ones changes no register.
- R11: In the wide variant, an access at an offset above 0x1F reads zero and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset inside the window |
| acc_strb | input | 4 | Byte strobes; only 4'b1111 writes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational, zero when no read is in progress |
| irq_in | input | 1 | Incoming interrupt request level |
| irq_out | output | 1 | Registered interrupt output |
| chan_en | output | 1 | Channel enable level |
| periph_rst | output | 1 | One-cycle reset pulse to the attached peripheral |

## Verification
Read data is combinational from the registers, so a write's effect shows on acc_rdata from the cycle after its capturing edge. The same one-edge latency applies to the loaded flag, the pending bit, irq_out, chan_en and the periph_rst pulse. The bench updates its reference model at each rising edge from the inputs that were stable before that edge. It compares every output at the following falling edge, so every result is checked in the cycle it first becomes due and in each cycle after.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

  localparam int REG_W    = 32;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int STRB_W   = REG_W / 8;
  localparam int WIDE_WORDS = 2 * NUM_REGS;
  localparam int WIDE_BYTES = WIDE_WORDS * STRB_W;

  localparam logic [REG_W-1:0] CTRL_RESET   = 32'hA000_0000;
  localparam logic [REG_W-1:0] CTRL_RO_MASK = 32'hFE00_0007;

  localparam int PEND_BIT   = 0;
  localparam int IEN_BIT    = 4;
  localparam int DRAIN_BIT  = 6;
  localparam int RSTCMD_BIT = 7;
  localparam int DIR_BIT    = 8;
  localparam int ENA_BIT    = 9;
  localparam int LOADED_BIT = 26;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 2'd0,
    IDX_ADDR  = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_UPPER = 2'd3
  } reg_idx_e;

  // word index from the low byte-offset bits; upper bits fold
  function automatic logic [IDX_W-1:0] reg_index(input logic [3:0] low_addr);
    return low_addr[3:2];
  endfunction

  function automatic logic full_word(input logic [STRB_W-1:0] strb);
    return &strb;
  endfunction

  function automatic logic in_window(input logic [31:0] byte_off, input logic wide);
    return !wide || (byte_off < 32'(WIDE_BYTES));
  endfunction

  // command bits: reset never stored, drain stored only alongside reset
  function automatic logic [REG_W-1:0] filter_cmd(input logic [REG_W-1:0] wdata);
    logic [REG_W-1:0] d;
    d = wdata;
    d[RSTCMD_BIT] = 1'b0;
    if (!wdata[RSTCMD_BIT]) d[DRAIN_BIT] = 1'b0;
    return d;
  endfunction

  function automatic logic [REG_W-1:0] merge_ctrl(input logic [REG_W-1:0] old_val,
                                                  input logic [REG_W-1:0] wdata);
    return (old_val & CTRL_RO_MASK) | (filter_cmd(wdata) & ~CTRL_RO_MASK);
  endfunction

endpackage

// File: rtl/dmachan_decode.sv
module dmachan_decode
  import dmachan_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter bit WIDE_WIN = 1'b1
) (
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [STRB_W-1:0]   acc_strb,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [IDX_W-1:0]    rd_idx,
  output logic                rd_live,
  output logic                in_win
);

  logic [IDX_W-1:0] idx;
  logic             wr_ok;

  generate
    if (WIDE_WIN) begin : g_wide
      assign in_win = in_window(32'(acc_addr), 1'b1);
    end else begin : g_narrow
      assign in_win = in_window(32'(acc_addr), 1'b0);
    end
  endgenerate

  assign idx     = reg_index(acc_addr[3:0]);
  assign wr_ok   = acc_valid & acc_write & full_word(acc_strb) & in_win;
  assign rd_idx  = idx;
  assign rd_live = acc_valid & ~acc_write & in_win;

  generate
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_hit
      assign wr_hit[gi] = wr_ok && (idx == IDX_W'(gi));
    end
  endgenerate

endmodule

// File: rtl/dmachan_ctrl.sv
module dmachan_ctrl
  import dmachan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             addr_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             irq_in,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] ctrl_d,
  output logic             chan_en,
  output logic             periph_rst
);

  logic rst_cmd;

  assign rst_cmd = ctrl_wr & wdata[RSTCMD_BIT];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = merge_ctrl(ctrl_q, wdata);
    if (addr_wr) ctrl_d[LOADED_BIT] = 1'b1;
    ctrl_d[PEND_BIT] = irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RESET;
      periph_rst <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      periph_rst <= rst_cmd;
    end
  end

  assign chan_en = ctrl_q[ENA_BIT];

  // R4
  ro_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q[31:25] == $past(ctrl_q[31:25])) && (ctrl_q[2:1] == $past(ctrl_q[2:1])));

  // R5
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> $past(ctrl_wr && wdata[RSTCMD_BIT]));

  // R6
  drain_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[RSTCMD_BIT]) |=> !ctrl_q[DRAIN_BIT]);

  // R3
  loaded_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ctrl_q[LOADED_BIT]);

  // R7
  en_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_en) |-> $past(ctrl_wr));

  // R8
  pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ctrl_q[PEND_BIT] == $past(irq_in)));

endmodule

// File: rtl/dmachan_irq.sv
module dmachan_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_d,
  input  logic ien_d,
  input  logic pend_q,
  input  logic ien_q,
  output logic irq_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_d & ien_d;
  end

  // R9
  irq_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_q && ien_q));

  // R9
  irq_when_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ien_q) |-> irq_out);

endmodule

// File: rtl/dmachan_regfile.sv
module dmachan_regfile
  import dmachan_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter bit WIDE_WIN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_strb,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              irq_in,
  output logic              irq_out,
  output logic              chan_en,
  output logic              periph_rst
);

  logic [NUM_REGS-1:0] wr_hit;
  logic [IDX_W-1:0]    rd_idx;
  logic                rd_live;
  logic                in_win;
  logic [REG_W-1:0]    ctrl_q;
  logic [REG_W-1:0]    ctrl_d;
  logic [REG_W-1:0]    data_q [NUM_REGS];

  dmachan_decode #(.ADDR_W(ADDR_W), .WIDE_WIN(WIDE_WIN)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_strb  (acc_strb),
    .wr_hit    (wr_hit),
    .rd_idx    (rd_idx),
    .rd_live   (rd_live),
    .in_win    (in_win)
  );

  dmachan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (wr_hit[IDX_CTRL]),
    .addr_wr    (wr_hit[IDX_ADDR]),
    .wdata      (acc_wdata),
    .irq_in     (irq_in),
    .ctrl_q     (ctrl_q),
    .ctrl_d     (ctrl_d),
    .chan_en    (chan_en),
    .periph_rst (periph_rst)
  );

  dmachan_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_d  (ctrl_d[PEND_BIT]),
    .ien_d   (ctrl_d[IEN_BIT]),
    .pend_q  (ctrl_q[PEND_BIT]),
    .ien_q   (ctrl_q[IEN_BIT]),
    .irq_out (irq_out)
  );

  generate
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      if (gi == int'(IDX_CTRL)) begin : g_hole
        assign data_q[gi] = '0;
      end else begin : g_plain
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)          data_q[gi] <= '0;
          else if (wr_hit[gi]) data_q[gi] <= acc_wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    acc_rdata = '0;
    if (rd_live) begin
      if (rd_idx == IDX_CTRL) acc_rdata = ctrl_q;
      else                    acc_rdata = data_q[rd_idx];
    end
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R10
  part_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_strb != 4'hF)
      |=> (data_q[IDX_ADDR] == $past(data_q[IDX_ADDR])) && (data_q[IDX_COUNT] == $past(data_q[IDX_COUNT])));

  generate
    if (WIDE_WIN) begin : g_win_chk
      // R11
      outside_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !in_win)
          |=> (data_q[IDX_UPPER] == $past(data_q[IDX_UPPER])) && (data_q[IDX_ADDR] == $past(data_q[IDX_ADDR])));
    end
  endgenerate

endmodule

// File: tb/tb_dmachan_regfile.sv
module tb_dmachan_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [3:0]  acc_strb = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        irq_in = 1'b0;
  logic        irq_out, chan_en, periph_rst;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference state
  bit [31:0] m_ctrl, m_addr, m_cnt, m_up;
  bit        m_irq, m_pulse;
  localparam bit [31:0] RO = 32'hFE00_0007;

  always #4 clk = ~clk;

  dmachan_regfile dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_strb(acc_strb), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .irq_in(irq_in), .irq_out(irq_out),
    .chan_en(chan_en), .periph_rst(periph_rst)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 32'hA000_0000; m_addr = 0; m_cnt = 0; m_up = 0;
      m_irq = 0; m_pulse = 0;
    end else begin
      bit [31:0] keep;
      m_pulse = 0;
      if (acc_valid && acc_write && acc_strb == 4'b1111 && acc_addr <= 8'h1F) begin
        case (acc_addr[3:2])
          2'd0: begin
            keep = acc_wdata & ~RO;
            keep[7] = 1'b0;
            if (acc_wdata[7] == 1'b0) keep[6] = 1'b0;
            m_ctrl = (m_ctrl & RO) | keep;
            m_pulse = acc_wdata[7];
          end
          2'd1: begin m_addr = acc_wdata; m_ctrl[26] = 1'b1; end
          2'd2: m_cnt = acc_wdata;
          default: m_up = acc_wdata;
        endcase
      end
      m_ctrl[0] = irq_in;
      m_irq = irq_in && m_ctrl[4];
    end
  end

  function automatic bit [31:0] m_read();
    if (!acc_valid || acc_write || acc_addr > 8'h1F) return 32'h0;
    case (acc_addr[3:2])
      2'd0: return m_ctrl;
      2'd1: return m_addr;
      2'd2: return m_cnt;
      default: return m_up;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "read data", acc_rdata, m_read());
      chk("R9", "irq_out", {31'b0, irq_out}, {31'b0, m_irq});
      chk("R7", "chan_en", {31'b0, chan_en}, {31'b0, m_ctrl[9]});
      chk("R5", "periph_rst", {31'b0, periph_rst}, {31'b0, m_pulse});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(posedge clk); #1;
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d; acc_strb = s;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(posedge clk); #1;
    acc_valid = 1; acc_write = 0; acc_addr = a;
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    cur_req = "R1";
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
    // R3 plain registers and loaded flag
    cur_req = "R3";
    wr(8'h04, 32'h1234_5678); rd(8'h04); rd(8'h00);
    wr(8'h08, 32'h0000_0FF0); wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h08); rd(8'h0C);
    // R2 folding of in-window offsets
    cur_req = "R2";
    rd(8'h14); wr(8'h18, 32'hCAFE_0001); rd(8'h08); rd(8'h1C);
    // R4 read-only bits
    cur_req = "R4";
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
    wr(8'h00, 32'h0000_0000); rd(8'h00);
    // R5 reset command pulse
    cur_req = "R5";
    wr(8'h00, 32'h0000_0080); rd(8'h00); idle(2);
    // R6 drain handling
    cur_req = "R6";
    wr(8'h00, 32'h0000_0040); rd(8'h00);
    wr(8'h00, 32'h0000_00C0); rd(8'h00);
    // R7 channel enable
    cur_req = "R7";
    wr(8'h00, 32'h0000_0200); idle(2); wr(8'h00, 32'h0000_0100); idle(2);
    // R8 pending follows irq_in
    cur_req = "R8";
    irq_in = 1; idle(1); rd(8'h00);
    // R9 interrupt output gating
    cur_req = "R9";
    wr(8'h00, 32'h0000_0010); idle(2);
    irq_in = 0; idle(2); irq_in = 1; idle(2);
    wr(8'h00, 32'h0000_0000); idle(2); irq_in = 0;
    // R10 partial strobes
    cur_req = "R10";
    wr(8'h04, 32'h5555_AAAA, 4'h7); rd(8'h04);
    wr(8'h00, 32'h0000_0210, 4'hE); rd(8'h00);
    // R11 outside the wide window
    cur_req = "R11";
    wr(8'h24, 32'h7777_7777); rd(8'h24); rd(8'h04); rd(8'h3C);
    // mixed traffic
    cur_req = "R2";
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      acc_valid = ($urandom % 4) != 0;
      acc_write = $urandom % 2;
      acc_addr  = 8'($urandom % 64);
      acc_strb  = (($urandom % 5) == 0) ? 4'($urandom) : 4'hF;
      acc_wdata = $urandom;
      irq_in    = ($urandom % 3) == 0;
    end
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0;
    idle(2);
    summary();
  end

endmodule